// File: doc/BRIEF.md
# Three-Wire Register Loader

This block is the serial configuration front end of a frequency synthesizer. A host drives a serial clock, a data line and a load-enable line. Each word is 24 bits long and is sent most significant bit first. When load-enable rises, the two lowest bits of the word choose which of four configuration latches receives the word: the control word, the reference-divider word, the feedback-divider word or the test word. All three serial lines are asynchronous to the system clock. They are synchronised, and their edges are detected, in the system clock domain.

Next to the latches, the block derives the controls that the rest of the synthesizer needs. It forms an effective charge-pump gain select from whichever of its two homes was written last. It holds the synthesizer in power-down with the charge pump in three-state until all three working latches have been written once. It carries out the programmed power-down mode, either immediately or synchronised to the reference-divider output. It also issues a one-cycle band-select start pulse for every feedback-divider write.

Top module: `cfg_loader`

## Requirements
- R1: Each rising edge of `serClk` shifts the current `serData` value into a 24-bit register, most significant bit first. If more than 24 bits are sent before a load, only the last 24 are kept.
- R2: A rising edge of `serLoad` copies the register into one latch chosen by its bits [1:0]: 00 control, 01 reference divider, 10 feedback divider, 11 test. The other three latches keep their contents.
- R3: `cpGain` takes bit 10 of each word loaded into the control latch and bit 21 of each word loaded into the feedback-divider latch. The last of these writes decides the value.
- R4: After reset, every latch reads zero and `powerDown`, `cpTriState` are high with `initDone` low. This holds until the control, reference and feedback latches have each been written at least once, in any order. `initDone` then rises and stays high until reset.
- R5: In a control word, bit 20 enables power-down and bit 21 selects the mode. Bit 20 = 0 returns the block to running. Bits 21:20 = 01 raise `powerDown` within a few system clocks and do not wait for `refDiv`.
- R6: Bits 21:20 = 11 leave the block running until the second rising edge of `refDiv` after the load. `powerDown` rises on that edge and not on the first one.
- R7: `bandStart` is a single-cycle pulse issued once for every load into the feedback-divider latch. Loads into the other latches do not produce it.
- R8: Loads into every latch are accepted while `powerDown` is high.
- R9: When running, `cpTriState` follows bit 9 of the control latch. Whenever `powerDown` is high, `cpTriState` is high regardless of that bit.
- R10: A control load with bit 20 = 0 that arrives while a synchronous power-down is waiting for its `refDiv` edges cancels it. Later `refDiv` edges then leave the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| serLoad | input | 1 | Load-enable, asynchronous |
| refDiv | input | 1 | Reference-divider output, asynchronous |
| ctrlWord | output | 24 | Control latch contents |
| rDivWord | output | 24 | Reference-divider latch contents |
| nDivWord | output | 24 | Feedback-divider latch contents |
| testWord | output | 24 | Test latch contents |
| cpGain | output | 1 | Effective charge-pump gain select |
| bandStart | output | 1 | One-cycle band-select start pulse |
| powerDown | output | 1 | Synthesizer power-down state |
| cpTriState | output | 1 | Charge-pump three-state control |
| initDone | output | 1 | All three working latches written since reset |

## Verification
The hardest situation to reach is a synchronous power-down that is still waiting for its second reference edge when a new control word arrives. Reaching it takes a full serial word, then exactly one `refDiv` pulse, then a second complete word, all before any further reference edge. The bench drives `refDiv` only through an explicit pulse task, so the edge count between loads is exact. It also places the cancelling write between the first and second pulses and then applies extra pulses to show that nothing happens late.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadCtrl;
    logic loadR;
    logic loadN;
    logic loadTest;
  } strobe_t;

  typedef enum logic [1:0] {
    PD_RUN  = 2'b00,
    PD_WAIT = 2'b01,
    PD_OFF  = 2'b10
  } pd_state_e;

  // Field positions whose meaning the control logic depends on
  localparam int CpgCtrlPos = 10;
  localparam int CpgNPos    = 21;
  localparam int CpTriPos   = 9;
  localparam int PdEnPos    = 20;
  localparam int PdModePos  = 21;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncd
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= asyncIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign syncd = chain[STAGES-1];

endmodule

// File: rtl/cfg_shift_path.sv
module cfg_shift_path
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  output logic [1:0]        wordSel,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] rDivWord,
  output logic [WORD_W-1:0] nDivWord,
  output logic [WORD_W-1:0] testWord,
  output logic              cpGain
);

  localparam int NumLatch = 4;

  logic [WORD_W-1:0]   shiftReg;
  logic [WORD_W-1:0]   bank [NumLatch];
  logic [NumLatch-1:0] loadVec;

  assign loadVec = {strb.loadTest, strb.loadN, strb.loadR, strb.loadCtrl};
  assign wordSel = shiftReg[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
  end

  for (genvar i = 0; i < NumLatch; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank[i] <= '0;
      else if (loadVec[i]) bank[i] <= shiftReg;
    end
  end

  // Gain select shared by two latches: the most recent load wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cpGain <= 1'b0;
    else if (strb.loadCtrl) cpGain <= shiftReg[CpgCtrlPos];
    else if (strb.loadN)    cpGain <= shiftReg[CpgNPos];
  end

  assign ctrlWord = bank[0];
  assign rDivWord = bank[1];
  assign nDivWord = bank[2];
  assign testWord = bank[3];

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_EDGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLoad,
  input  logic       refDiv,
  input  logic [1:0] wordSel,
  input  logic       pdEn,
  input  logic       pdMode,
  input  logic       triBit,
  output strobe_t    strb,
  output logic       bandStart,
  output logic       powerDown,
  output logic       cpTriState,
  output logic       initDone
);

  localparam int EdgeW = $clog2(PD_EDGES + 1);

  logic [3:0]       lvl;
  logic [2:0]       prevLvl;
  logic             clkRise, loadRise, refRise;
  logic             ctrlLoadD;
  logic [2:0]       seen;
  pd_state_e        pdState;
  logic [EdgeW-1:0] edgeCnt;

  cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn({refDiv, serLoad, serData, serClk}),
    .syncd  (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= '0;
    else        prevLvl <= {lvl[3], lvl[2], lvl[0]};
  end

  assign clkRise  = lvl[0] & ~prevLvl[0];
  assign loadRise = lvl[2] & ~prevLvl[1];
  assign refRise  = lvl[3] & ~prevLvl[2];

  always_comb begin
    strb          = '0;
    strb.shiftEn  = clkRise;
    strb.shiftBit = lvl[1];
    strb.loadCtrl = loadRise && (wordSel == 2'b00);
    strb.loadR    = loadRise && (wordSel == 2'b01);
    strb.loadN    = loadRise && (wordSel == 2'b10);
    strb.loadTest = loadRise && (wordSel == 2'b11);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlLoadD <= 1'b0;
      bandStart <= 1'b0;
      seen      <= '0;
    end else begin
      ctrlLoadD <= strb.loadCtrl;
      bandStart <= strb.loadN;
      seen      <= seen | {strb.loadN, strb.loadR, strb.loadCtrl};
    end
  end

  assign initDone = &seen;

  // Power-down mode sequencer; evaluated the cycle after the control load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdState <= PD_RUN;
      edgeCnt <= '0;
    end else if (ctrlLoadD) begin
      edgeCnt <= '0;
      if (!pdEn)                  pdState <= PD_RUN;
      else if (!pdMode)           pdState <= PD_OFF;
      else if (pdState != PD_OFF) pdState <= PD_WAIT;
    end else if (pdState == PD_WAIT && refRise) begin
      if (edgeCnt == EdgeW'(PD_EDGES - 1)) pdState <= PD_OFF;
      else                                 edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign powerDown  = !initDone || (pdState == PD_OFF);
  assign cpTriState = powerDown || triBit;

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int PD_EDGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  input  logic              refDiv,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] rDivWord,
  output logic [WORD_W-1:0] nDivWord,
  output logic [WORD_W-1:0] testWord,
  output logic              cpGain,
  output logic              bandStart,
  output logic              powerDown,
  output logic              cpTriState,
  output logic              initDone
);

  strobe_t    strb;
  logic [1:0] wordSel;

  cfg_shift_path #(.WORD_W(WORD_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wordSel (wordSel),
    .ctrlWord(ctrlWord),
    .rDivWord(rDivWord),
    .nDivWord(nDivWord),
    .testWord(testWord),
    .cpGain  (cpGain)
  );

  cfg_seq_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PD_EDGES(PD_EDGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .serClk    (serClk),
    .serData   (serData),
    .serLoad   (serLoad),
    .refDiv    (refDiv),
    .wordSel   (wordSel),
    .pdEn      (ctrlWord[PdEnPos]),
    .pdMode    (ctrlWord[PdModePos]),
    .triBit    (ctrlWord[CpTriPos]),
    .strb      (strb),
    .bandStart (bandStart),
    .powerDown (powerDown),
    .cpTriState(cpTriState),
    .initDone  (initDone)
  );

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input strobe_t           strb,
  input logic [WORD_W-1:0] rDivWord,
  input logic [WORD_W-1:0] testWord,
  input logic              bandStart,
  input logic              powerDown,
  input logic              cpTriState,
  input logic              initDone
);

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadCtrl, strb.loadR, strb.loadN, strb.loadTest}));

  assert_rdiv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadR |=> $stable(rDivWord));

  assert_test_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadTest |=> $stable(testWord));

  assert_down_before_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !initDone |-> powerDown);

  assert_init_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    initDone |=> initDone);

  assert_band_after_nload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadN |=> bandStart);

  assert_band_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bandStart |=> !bandStart);

  assert_tri_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |-> cpTriState);

endmodule

bind cfg_loader cfg_loader_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strb      (strb),
  .rDivWord  (rDivWord),
  .testWord  (testWord),
  .bandStart (bandStart),
  .powerDown (powerDown),
  .cpTriState(cpTriState),
  .initDone  (initDone)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, refDiv = 1'b0;
  logic [23:0] ctrlWord, rDivWord, nDivWord, testWord;
  logic cpGain, bandStart, powerDown, cpTriState, initDone;

  int testCnt = 0;
  int failCnt = 0;
  int bandSeen = 0;
  bit finished = 0;

  logic [23:0] mCtrl = '0, mR = '0, mN = '0, mT = '0;
  logic        mCpg = 1'b0;
  int          mBand = 0;

  always #2 clk = ~clk;

  cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .refDiv(refDiv), .ctrlWord(ctrlWord),
    .rDivWord(rDivWord), .nDivWord(nDivWord), .testWord(testWord),
    .cpGain(cpGain), .bandStart(bandStart), .powerDown(powerDown),
    .cpTriState(cpTriState), .initDone(initDone)
  );

  always @(negedge clk) if (rst_n && bandStart) bandSeen++;

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      waitClk(4);
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
    end
  endtask

  task automatic pulseLoad();
    waitClk(2);
    serLoad = 1'b1;
    waitClk(6);
    serLoad = 1'b0;
    waitClk(8);
  endtask

  // Reference model update following R2, R3, R7
  function automatic void modelLoad(input logic [23:0] w);
    case (w[1:0])
      2'b00: begin mCtrl = w; mCpg = w[10]; end
      2'b01: mR = w;
      2'b10: begin mN = w; mCpg = w[21]; mBand++; end
      default: mT = w;
    endcase
  endfunction

  task automatic sendWord(input logic [23:0] w);
    shiftBits({8'h00, w}, 24);
    pulseLoad();
    modelLoad(w);
  endtask

  task automatic refPulse();
    refDiv = 1'b1;
    waitClk(4);
    refDiv = 1'b0;
    waitClk(6);
  endtask

  task automatic checkLatches(input string req);
    @(negedge clk);
    check(req, {8'h0, ctrlWord}, {8'h0, mCtrl});
    check(req, {8'h0, rDivWord}, {8'h0, mR});
    check(req, {8'h0, nDivWord}, {8'h0, mN});
    check(req, {8'h0, testWord}, {8'h0, mT});
    check(req, 32'(cpGain), 32'(mCpg));
    check(req, bandSeen, mBand);
    waitClk(1);
  endtask

  task automatic checkPd(input string req, input logic pd, input logic tri_);
    @(negedge clk);
    check(req, 32'(powerDown), 32'(pd));
    check(req, 32'(cpTriState), 32'(tri_));
    waitClk(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'h0000_5EED));
    waitClk(4);
    rst_n = 1'b1;
    waitClk(4);

    // R4: reset state
    checkLatches("R4 reset latches");
    checkPd("R4 reset down", 1'b1, 1'b1);
    @(negedge clk); check("R4 initDone low", 32'(initDone), 32'd0); waitClk(1);

    // R1, R2: reference word, still held down (R4)
    sendWord(24'hABCDE5);
    checkLatches("R1 R2 reference load");
    checkPd("R4 down after one write", 1'b1, 1'b1);

    // R3: control word with gain bit 10 set, bit 9 clear, bit 20 clear
    sendWord(24'h000400);
    checkLatches("R3 gain via control");
    checkPd("R4 down after two writes", 1'b1, 1'b1);

    // Feedback word with bit 21 clear completes init (R4, R3, R7, R9)
    sendWord(24'h012346);
    checkLatches("R3 R7 gain via feedback");
    @(negedge clk); check("R4 initDone high", 32'(initDone), 32'd1); waitClk(1);
    checkPd("R4 R9 running after init", 1'b0, 1'b0);

    // R1: 30 bits sent; only the last 24 kept
    shiftBits(32'h3F5A5A5D, 30);
    pulseLoad();
    modelLoad(24'h5A5A5D);
    checkLatches("R1 overlong shift");

    // R9: three-state bit while running
    sendWord(24'h000200);
    checkPd("R9 tri bit follows", 1'b0, 1'b1);

    // R5: immediate power-down, no refDiv activity
    sendWord(24'h100000);
    checkPd("R5 R9 immediate down", 1'b1, 1'b1);

    // R8: loads while down; test load gives no band pulse (R7)
    sendWord(24'h0F0F0D);
    sendWord(24'h123457);
    checkLatches("R8 R7 loads while down");
    sendWord(24'h2000AA);
    checkLatches("R8 R7 feedback while down");
    checkPd("R8 still down", 1'b1, 1'b1);

    // R5: bit 20 clear returns to running
    sendWord(24'h000000);
    checkPd("R5 back to run", 1'b0, 1'b0);

    // R6: synchronous power-down on second refDiv edge
    sendWord(24'h300000);
    checkPd("R6 waiting, no edge", 1'b0, 1'b0);
    refPulse();
    checkPd("R6 after first edge", 1'b0, 1'b0);
    refPulse();
    checkPd("R6 after second edge", 1'b1, 1'b1);

    // R10: cancel a pending synchronous power-down
    sendWord(24'h000000);
    checkPd("R10 run before", 1'b0, 1'b0);
    sendWord(24'h300000);
    refPulse();
    sendWord(24'h000000);
    refPulse();
    refPulse();
    refPulse();
    checkPd("R10 cancelled", 1'b0, 1'b0);

    // R2, R3, R7: random words, control words kept running (bits 21:20 clear)
    for (int k = 0; k < 40; k++) begin
      w = 24'($urandom());
      if (w[1:0] == 2'b00) w[21:20] = 2'b00;
      if (k % 9 == 0) w[1:0] = 2'b10;
      sendWord(w);
      checkLatches("R2 R3 R7 random");
    end
    @(negedge clk); check("R5 running after random", 32'(powerDown), 32'd0);

    finished = 1;
    summary();
  end

endmodule